// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the transmit and receive queues of a serial peripheral controller and reports their state to software over a small word-addressed register bus. Software loads transmit words through a data register and drains received words through the same register. A separate serial shifter, which is not part of this block, takes transmit words through a pop strobe and delivers received words through a push strobe.

The unit keeps an occupancy count for each queue. It derives a status word and five interrupt causes from those counts: two are threshold comparisons and three are sticky error flags. A mask register selects which causes drive the single interrupt line. Two request lines pace a DMA engine, one for each direction, and each has its own enable bit and level register. The queue depth is a parameter from 2 to 32, and the threshold registers refuse values at or above the depth, so software can find the depth by probing them. A global enable bit gates all queue traffic. Clearing it empties both queues.

Top module: `spi_fifo_status_unit`

## Requirements
- R1: After reset both levels are 0, status reads 0x0C with the busy input low, raw interrupts read 0x01, masked interrupts read 0, the TX and RX thresholds read 0, and irq, both DMA requests and shf_tx_valid are low.
- R2: When enabled, a bus write to address 13 pushes a TX word. TX level (address 3) reports the count, and the shifter receives words on shf_tx_data in write order, advancing on shf_tx_pop.
- R3: When enabled, shf_rx_push stores shf_rx_data. A bus read of address 13 returns the oldest RX word and removes it, and RX level (address 4) reports the count.
- R4: Status (address 5): bit0 follows shf_busy, bit1 TX full, bit2 TX empty, bit3 RX empty, bit4 RX full.
- R5: Raw interrupts (address 8): bit0 is set while TX level is at or below the TX threshold (address 1), and bit4 is set while RX level exceeds the RX threshold (address 2).
- R6: A TX push while the TX queue is full is dropped and sets sticky raw bit1.
- R7: An RX data read while the RX queue is empty returns 0 and sets sticky raw bit2.
- R8: An RX push from the shifter while the RX queue is full is dropped and sets sticky raw bit3.
- R9: Writing the clear register (address 9) acts per bit: bit0 clears every error flag, bit1 clears raw bit2, bit2 clears raw bit3, and bit3 clears raw bit1.
- R10: Masked status (address 7) reads raw AND mask, where the mask is at address 6. irq is high when any masked bit is set.
- R11: The threshold and DMA level registers (addresses 1, 2, 11, 12) ignore written values at or above DEPTH and keep their previous value.
- R12: DMA control (address 10) bit1 enables tx_dma_req, which is high while TX level is at or below the TX DMA level (address 11). Bit0 enables rx_dma_req, which is high while RX level exceeds the RX DMA level (address 12).
- R13: Enable is bit0 of address 0. While it is low, pushes and pops are ignored without setting flags. From the cycle after it is cleared, both levels read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 13 pops the RX queue |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational while bus_rd is high |
| shf_busy | input | 1 | Shifter busy, reported in status bit0 |
| shf_tx_pop | input | 1 | Shifter takes the TX head word |
| shf_tx_data | output | DW | TX head word, zero when empty |
| shf_tx_valid | output | 1 | TX queue holds a word |
| shf_rx_push | input | 1 | Shifter delivers a received word |
| shf_rx_data | input | DW | Received word |
| irq | output | 1 | OR of masked interrupt causes |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The sticky error flags are the hardest cases to reach from the ports. Each one needs a queue driven exactly to its limit and then one step past it, while the level, status and data order around the dropped word stay intact. The stimulus fills TX to DEPTH with a known sequence and writes one more word. It then drains TX through the shifter port, checking that the extra word never appears. It overfills RX from the shifter side in the same way. Finally it drains RX one read past empty, with the clear bits applied one at a time so that each bit clears only its own flag.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_TXTHR = 4'd1,
        A_RXTHR = 4'd2,
        A_TXLVL = 4'd3,
        A_RXLVL = 4'd4,
        A_STAT  = 4'd5,
        A_IMASK = 4'd6,
        A_ISTAT = 4'd7,
        A_IRAW  = 4'd8,
        A_ICLR  = 4'd9,
        A_DMAC  = 4'd10,
        A_TXDMA = 4'd11,
        A_RXDMA = 4'd12,
        A_DATA  = 4'd13
    } reg_addr_e;

    // status word bits
    localparam int ST_BUSY   = 0;
    localparam int ST_TXFULL = 1;
    localparam int ST_TXEMP  = 2;
    localparam int ST_RXEMP  = 3;
    localparam int ST_RXFULL = 4;

    // interrupt cause bits (raw, mask, masked)
    localparam int IRQ_W     = 5;
    localparam int IQ_TXLOW  = 0;
    localparam int IQ_TXOVF  = 1;
    localparam int IQ_RXUNF  = 2;
    localparam int IQ_RXOVF  = 3;
    localparam int IQ_RXHIGH = 4;

    // clear register bits
    localparam int CL_ALL   = 0;
    localparam int CL_RXUNF = 1;
    localparam int CL_RXOVF = 2;
    localparam int CL_TXOVF = 3;

    // DMA control bits
    localparam int DM_RX = 0;
    localparam int DM_TX = 1;

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [LW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        full    = (st_q.cnt == LW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = step_ptr(st_q.wr);
            if (do_pop)  st_d.rd = step_ptr(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + LW'(1);
                2'b01:   st_d.cnt = st_q.cnt - LW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    assign head  = mem_q[st_q.rd];
    assign level = st_q.cnt;

endmodule

// File: rtl/sfs_csr.sv
module sfs_csr
    import sfs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              shf_busy,
    input  logic              shf_rx_push,
    input  logic [LW-1:0]     tx_lvl,
    input  logic [LW-1:0]     rx_lvl,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic [DW-1:0]     rx_head,
    output logic              en,
    output logic              tx_push,
    output logic              rx_pop,
    output logic              rx_push,
    output logic [IRQ_W-1:0]  raw_int,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);

    typedef struct packed {
        logic             en;
        logic [TW-1:0]    tx_thr;
        logic [TW-1:0]    rx_thr;
        logic [IRQ_W-1:0] mask;
        logic [1:0]       dmac;
        logic [TW-1:0]    tx_dma;
        logic [TW-1:0]    rx_dma;
        logic             tx_ovf;
        logic             rx_unf;
        logic             rx_ovf;
    } csr_st_t;

    csr_st_t          st_d, st_q;
    logic             wr_ok_lvl;
    logic [4:0]       status;
    logic [IRQ_W-1:0] masked;

    // traffic strobes, all gated by the registered enable
    always_comb begin
        tx_push = st_q.en && bus_wr && (bus_addr == A_DATA);
        rx_pop  = st_q.en && bus_rd && (bus_addr == A_DATA);
        rx_push = st_q.en && shf_rx_push;
    end

    // next-state computation
    always_comb begin
        wr_ok_lvl = (bus_wdata < DW'(DEPTH));
        st_d      = st_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  st_d.en   = bus_wdata[0];
                A_TXTHR: if (wr_ok_lvl) st_d.tx_thr = TW'(bus_wdata);
                A_RXTHR: if (wr_ok_lvl) st_d.rx_thr = TW'(bus_wdata);
                A_TXDMA: if (wr_ok_lvl) st_d.tx_dma = TW'(bus_wdata);
                A_RXDMA: if (wr_ok_lvl) st_d.rx_dma = TW'(bus_wdata);
                A_IMASK: st_d.mask = bus_wdata[IRQ_W-1:0];
                A_DMAC:  st_d.dmac = bus_wdata[1:0];
                A_ICLR: begin
                    if (bus_wdata[CL_ALL]) begin
                        st_d.tx_ovf = 1'b0;
                        st_d.rx_unf = 1'b0;
                        st_d.rx_ovf = 1'b0;
                    end
                    if (bus_wdata[CL_RXUNF]) st_d.rx_unf = 1'b0;
                    if (bus_wdata[CL_RXOVF]) st_d.rx_ovf = 1'b0;
                    if (bus_wdata[CL_TXOVF]) st_d.tx_ovf = 1'b0;
                end
                default: ;
            endcase
        end
        // error events win over a clear in the same cycle
        if (tx_push && tx_full)  st_d.tx_ovf = 1'b1;
        if (rx_pop  && rx_empty) st_d.rx_unf = 1'b1;
        if (rx_push && rx_full)  st_d.rx_ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // derived status, interrupt and request outputs
    always_comb begin
        status            = '0;
        status[ST_BUSY]   = shf_busy;
        status[ST_TXFULL] = tx_full;
        status[ST_TXEMP]  = tx_empty;
        status[ST_RXEMP]  = rx_empty;
        status[ST_RXFULL] = rx_full;

        raw_int            = '0;
        raw_int[IQ_TXLOW]  = (tx_lvl <= LW'(st_q.tx_thr));
        raw_int[IQ_TXOVF]  = st_q.tx_ovf;
        raw_int[IQ_RXUNF]  = st_q.rx_unf;
        raw_int[IQ_RXOVF]  = st_q.rx_ovf;
        raw_int[IQ_RXHIGH] = (rx_lvl > LW'(st_q.rx_thr));

        masked     = raw_int & st_q.mask;
        irq        = |masked;
        tx_dma_req = st_q.dmac[DM_TX] && (tx_lvl <= LW'(st_q.tx_dma));
        rx_dma_req = st_q.dmac[DM_RX] && (rx_lvl >  LW'(st_q.rx_dma));
        en         = st_q.en;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = DW'(st_q.en);
                A_TXTHR: bus_rdata = DW'(st_q.tx_thr);
                A_RXTHR: bus_rdata = DW'(st_q.rx_thr);
                A_TXLVL: bus_rdata = DW'(tx_lvl);
                A_RXLVL: bus_rdata = DW'(rx_lvl);
                A_STAT:  bus_rdata = DW'(status);
                A_IMASK: bus_rdata = DW'(st_q.mask);
                A_ISTAT: bus_rdata = DW'(masked);
                A_IRAW:  bus_rdata = DW'(raw_int);
                A_DMAC:  bus_rdata = DW'(st_q.dmac);
                A_TXDMA: bus_rdata = DW'(st_q.tx_dma);
                A_RXDMA: bus_rdata = DW'(st_q.rx_dma);
                A_DATA:  bus_rdata = rx_empty ? '0 : rx_head;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_fifo_status_unit.sv
module spi_fifo_status_unit
    import sfs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              shf_busy,
    input  logic              shf_tx_pop,
    output logic [DW-1:0]     shf_tx_data,
    output logic              shf_tx_valid,
    input  logic              shf_rx_push,
    input  logic [DW-1:0]     shf_rx_data,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);

    localparam int LW = $clog2(DEPTH + 1);

    logic             en, tx_push, rx_pop, rx_push;
    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]    tx_head, rx_head;
    logic [IRQ_W-1:0] raw_int;

    sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!en),
        .push  (tx_push),
        .wdata (bus_wdata),
        .pop   (shf_tx_pop),
        .head  (tx_head),
        .level (tx_lvl),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!en),
        .push  (rx_push),
        .wdata (shf_rx_data),
        .pop   (rx_pop),
        .head  (rx_head),
        .level (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sfs_csr #(.DW(DW), .DEPTH(DEPTH)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .shf_busy    (shf_busy),
        .shf_rx_push (shf_rx_push),
        .tx_lvl      (tx_lvl),
        .rx_lvl      (rx_lvl),
        .tx_full     (tx_full),
        .tx_empty    (tx_empty),
        .rx_full     (rx_full),
        .rx_empty    (rx_empty),
        .rx_head     (rx_head),
        .en          (en),
        .tx_push     (tx_push),
        .rx_pop      (rx_pop),
        .rx_push     (rx_push),
        .raw_int     (raw_int),
        .irq         (irq),
        .tx_dma_req  (tx_dma_req),
        .rx_dma_req  (rx_dma_req)
    );

    assign shf_tx_valid = !tx_empty;
    assign shf_tx_data  = tx_empty ? '0 : tx_head;

endmodule

// File: rtl/spi_fifo_status_unit_chk.sv
module spi_fifo_status_unit_chk
    import sfs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [LW-1:0]     tx_lvl,
    input logic [LW-1:0]     rx_lvl,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic [IRQ_W-1:0]  raw_int,
    input logic              irq,
    input logic              rx_dma_req
);

    p_flush_levels_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_lvl == '0) && (rx_lvl == '0));

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

    p_tx_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    p_tx_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_wr && bus_addr == A_DATA && tx_full) |=> raw_int[IQ_TXOVF]);

    p_tx_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_int[IQ_TXOVF] && !(bus_wr && bus_addr == A_ICLR &&
            (bus_wdata[CL_ALL] || bus_wdata[CL_TXOVF]))) |=> raw_int[IQ_TXOVF]);

    p_unf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA && rx_empty) |-> (bus_rdata == '0));

    p_unf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_rd && bus_addr == A_DATA && rx_empty) |=> raw_int[IQ_RXUNF]);

    p_rx_high_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        raw_int[IQ_RXHIGH] |-> !rx_empty);

    p_rx_dma_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> !rx_empty);

    p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_int != '0));

endmodule

bind spi_fifo_status_unit spi_fifo_status_unit_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_lvl     (tx_lvl),
    .rx_lvl     (rx_lvl),
    .tx_full    (tx_full),
    .tx_empty   (tx_empty),
    .rx_empty   (rx_empty),
    .raw_int    (raw_int),
    .irq        (irq),
    .rx_dma_req (rx_dma_req)
);

// File: tb/spi_fifo_status_unit_tb.sv
module spi_fifo_status_unit_tb;
    import sfs_pkg::*;

    localparam int DW    = 16;
    localparam int DEPTH = 8;

    localparam logic [2:0] OP_WR  = 3'd0; // bus write
    localparam logic [2:0] OP_RD  = 3'd1; // bus read, compare rdata
    localparam logic [2:0] OP_SP  = 3'd2; // shifter RX push
    localparam logic [2:0] OP_TP  = 3'd3; // shifter TX pop, compare head first
    localparam logic [2:0] OP_PIN = 3'd4; // compare {irq, tx_dma_req, rx_dma_req}

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [NV] = '{
        '{OP_WR,  A_CTRL,  16'h0001, 16'h0000, 4'd2 },  // R2 enable
        '{OP_RD,  A_TXLVL, 16'h0000, 16'h0000, 4'd2 },  // R2
        '{OP_WR,  A_DATA,  16'h1111, 16'h0000, 4'd2 },  // R2
        '{OP_WR,  A_DATA,  16'h2222, 16'h0000, 4'd2 },  // R2
        '{OP_WR,  A_DATA,  16'h3333, 16'h0000, 4'd2 },  // R2
        '{OP_RD,  A_TXLVL, 16'h0000, 16'h0003, 4'd2 },  // R2
        '{OP_RD,  A_STAT,  16'h0000, 16'h0008, 4'd4 },  // R4
        '{OP_TP,  A_CTRL,  16'h0000, 16'h1111, 4'd2 },  // R2 order
        '{OP_TP,  A_CTRL,  16'h0000, 16'h2222, 4'd2 },  // R2 order
        '{OP_RD,  A_TXLVL, 16'h0000, 16'h0001, 4'd2 },  // R2
        '{OP_WR,  A_TXTHR, 16'h0002, 16'h0000, 4'd5 },  // R5
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0001, 4'd5 },  // R5 level 1 <= 2
        '{OP_WR,  A_TXTHR, 16'h0000, 16'h0000, 4'd5 },  // R5
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0000, 4'd5 },  // R5 level 1 > 0
        '{OP_SP,  A_CTRL,  16'hAAAA, 16'h0000, 4'd3 },  // R3
        '{OP_SP,  A_CTRL,  16'hBBBB, 16'h0000, 4'd3 },  // R3
        '{OP_SP,  A_CTRL,  16'hCCCC, 16'h0000, 4'd3 },  // R3
        '{OP_RD,  A_RXLVL, 16'h0000, 16'h0003, 4'd3 },  // R3
        '{OP_WR,  A_RXTHR, 16'h0002, 16'h0000, 4'd5 },  // R5
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0010, 4'd5 },  // R5 3 > 2
        '{OP_WR,  A_RXTHR, 16'h0003, 16'h0000, 4'd5 },  // R5
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0000, 4'd5 },  // R5 3 not > 3
        '{OP_WR,  A_RXTHR, 16'h0009, 16'h0000, 4'd11},  // R11 refused
        '{OP_RD,  A_RXTHR, 16'h0000, 16'h0003, 4'd11},  // R11
        '{OP_WR,  A_RXTHR, 16'h0007, 16'h0000, 4'd11},  // R11 accepted
        '{OP_RD,  A_RXTHR, 16'h0000, 16'h0007, 4'd11},  // R11
        '{OP_WR,  A_RXTHR, 16'h0008, 16'h0000, 4'd11},  // R11 DEPTH refused
        '{OP_RD,  A_RXTHR, 16'h0000, 16'h0007, 4'd11},  // R11
        '{OP_RD,  A_DATA,  16'h0000, 16'hAAAA, 4'd3 },  // R3
        '{OP_RD,  A_DATA,  16'h0000, 16'hBBBB, 4'd3 },  // R3
        '{OP_RD,  A_RXLVL, 16'h0000, 16'h0001, 4'd3 },  // R3
        '{OP_RD,  A_DATA,  16'h0000, 16'hCCCC, 4'd3 },  // R3
        '{OP_RD,  A_DATA,  16'h0000, 16'h0000, 4'd7 },  // R7 empty read
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0004, 4'd7 },  // R7 flag
        '{OP_WR,  A_IMASK, 16'h0004, 16'h0000, 4'd10},  // R10
        '{OP_RD,  A_ISTAT, 16'h0000, 16'h0004, 4'd10},  // R10
        '{OP_PIN, A_CTRL,  16'h0000, 16'h0004, 4'd10},  // R10 irq high
        '{OP_WR,  A_IMASK, 16'h0001, 16'h0000, 4'd10},  // R10
        '{OP_RD,  A_ISTAT, 16'h0000, 16'h0000, 4'd10},  // R10
        '{OP_WR,  A_ICLR,  16'h0002, 16'h0000, 4'd9 },  // R9 bit1
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0000, 4'd9 },  // R9
        '{OP_WR,  A_TXDMA, 16'h0002, 16'h0000, 4'd12},  // R12
        '{OP_WR,  A_DMAC,  16'h0002, 16'h0000, 4'd12},  // R12
        '{OP_PIN, A_CTRL,  16'h0000, 16'h0002, 4'd12},  // R12 tx req
        '{OP_WR,  A_TXDMA, 16'h0000, 16'h0000, 4'd12},  // R12
        '{OP_PIN, A_CTRL,  16'h0000, 16'h0000, 4'd12},  // R12
        '{OP_WR,  A_DMAC,  16'h0003, 16'h0000, 4'd12},  // R12
        '{OP_PIN, A_CTRL,  16'h0000, 16'h0000, 4'd12},  // R12 rx empty
        '{OP_SP,  A_CTRL,  16'h1234, 16'h0000, 4'd12},  // R12
        '{OP_PIN, A_CTRL,  16'h0000, 16'h0001, 4'd12},  // R12 rx req
        '{OP_WR,  A_CTRL,  16'h0000, 16'h0000, 4'd13},  // R13 disable
        '{OP_RD,  A_CTRL,  16'h0000, 16'h0000, 4'd13},  // R13
        '{OP_RD,  A_TXLVL, 16'h0000, 16'h0000, 4'd13},  // R13
        '{OP_RD,  A_RXLVL, 16'h0000, 16'h0000, 4'd13},  // R13
        '{OP_WR,  A_DATA,  16'h5555, 16'h0000, 4'd13},  // R13 dropped
        '{OP_RD,  A_TXLVL, 16'h0000, 16'h0000, 4'd13},  // R13
        '{OP_RD,  A_IRAW,  16'h0000, 16'h0001, 4'd13},  // R13 no flag
        '{OP_PIN, A_CTRL,  16'h0000, 16'h0006, 4'd13}   // R13 irq + tx req
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              shf_busy = 1'b0, shf_tx_pop = 1'b0, shf_rx_push = 1'b0;
    logic [DW-1:0]     shf_tx_data, shf_rx_data = '0;
    logic              shf_tx_valid, irq, tx_dma_req, rx_dma_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    spi_fifo_status_unit #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .shf_busy     (shf_busy),
        .shf_tx_pop   (shf_tx_pop),
        .shf_tx_data  (shf_tx_data),
        .shf_tx_valid (shf_tx_valid),
        .shf_rx_push  (shf_rx_push),
        .shf_rx_data  (shf_rx_data),
        .irq          (irq),
        .tx_dma_req   (tx_dma_req),
        .rx_dma_req   (rx_dma_req)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input int rq, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [3:0] addr,
                       input logic [15:0] data, input logic [15:0] exp, input int rq);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = data;
        case (op)
            OP_WR: bus_wr = 1'b1;
            OP_RD: bus_rd = 1'b1;
            OP_SP: begin shf_rx_push = 1'b1; shf_rx_data = data; end
            OP_TP: shf_tx_pop = 1'b1;
            default: ;
        endcase
        #1;
        case (op)
            OP_RD:  check(bus_rdata, exp, rq, $sformatf("read addr %0d", addr));
            OP_TP:  check(shf_tx_data, exp, rq, "tx head");
            OP_PIN: check({13'd0, irq, tx_dma_req, rx_dma_req}, exp, rq, "pins");
            default: ;
        endcase
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        shf_rx_push = 1'b0;
        shf_tx_pop = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].exp, int'(VEC[i].req));

        // R1: reset state after a second reset
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run(OP_RD,  A_STAT,  0, 16'h000C, 1);   // R1
        run(OP_RD,  A_IRAW,  0, 16'h0001, 1);   // R1
        run(OP_RD,  A_ISTAT, 0, 16'h0000, 1);   // R1
        run(OP_RD,  A_TXLVL, 0, 16'h0000, 1);   // R1
        run(OP_RD,  A_RXLVL, 0, 16'h0000, 1);   // R1
        run(OP_RD,  A_RXTHR, 0, 16'h0000, 1);   // R1
        run(OP_RD,  A_TXTHR, 0, 16'h0000, 1);   // R1
        run(OP_PIN, A_CTRL,  0, 16'h0000, 1);   // R1
        check({15'd0, shf_tx_valid}, 16'h0000, 1, "tx valid after reset"); // R1

        // R6: fill TX past full
        run(OP_WR, A_CTRL, 16'h0001, 0, 6);
        for (int i = 0; i < DEPTH; i++) run(OP_WR, A_DATA, 16'h0100 + 16'(i), 0, 6);
        run(OP_RD, A_TXLVL, 0, 16'(DEPTH), 6);  // R6
        run(OP_RD, A_STAT,  0, 16'h000A, 4);    // R4 TX full, RX empty
        run(OP_WR, A_DATA,  16'hDEAD, 0, 6);    // R6 dropped push
        run(OP_RD, A_TXLVL, 0, 16'(DEPTH), 6);  // R6
        run(OP_RD, A_IRAW,  0, 16'h0002, 6);    // R6 flag
        for (int i = 0; i < DEPTH; i++) run(OP_TP, A_CTRL, 0, 16'h0100 + 16'(i), 6); // R6
        run(OP_RD, A_TXLVL, 0, 16'h0000, 6);    // R6
        run(OP_RD, A_IRAW,  0, 16'h0003, 6);    // R6 sticky
        run(OP_WR, A_ICLR,  16'h0001, 0, 9);    // R9 clear all
        run(OP_RD, A_IRAW,  0, 16'h0001, 9);    // R9

        // R8: fill RX past full from the shifter
        for (int i = 0; i <= DEPTH; i++) run(OP_SP, A_CTRL, 16'h0200 + 16'(i), 0, 8);
        run(OP_RD, A_STAT,  0, 16'h0014, 4);    // R4 TX empty, RX full
        run(OP_RD, A_IRAW,  0, 16'h0019, 8);    // R8 flag
        run(OP_WR, A_ICLR,  16'h0004, 0, 9);    // R9 bit2
        run(OP_RD, A_IRAW,  0, 16'h0011, 9);    // R9
        for (int i = 0; i < DEPTH; i++) run(OP_RD, A_DATA, 0, 16'h0200 + 16'(i), 8); // R8
        run(OP_RD, A_DATA,  0, 16'h0000, 7);    // R7
        run(OP_WR, A_ICLR,  16'h0008, 0, 9);    // R9 bit3 leaves underflow
        run(OP_RD, A_IRAW,  0, 16'h0005, 9);    // R9

        // R4: busy input
        shf_busy = 1'b1;
        run(OP_RD, A_STAT, 0, 16'h000D, 4);     // R4
        shf_busy = 1'b0;

        // R11: TX threshold probe at DEPTH
        run(OP_WR, A_TXTHR, 16'(DEPTH), 0, 11); // R11
        run(OP_RD, A_TXTHR, 0, 16'h0000, 11);   // R11

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule